// File: doc/BRIEF.md
# Dual-processor mailbox flag controller

Two processors use this block to tell each other that a message is waiting, channel by channel. Each processor owns one occupancy flag per channel. The owner raises its flag after it posts a message. The partner lowers that flag once it has consumed the message. Neither side can change its own flag in the other direction. No payload passes through the block: it holds only the flags, a per-processor control word, a per-processor mask word and two read-only identification words.

Each processor has its own word-addressed register port with a write strobe and a combinational read path. Either port can read every register. A write takes effect only in the bank that belongs to the writing port. Each processor gets two interrupts. The receive interrupt says that some unmasked partner flag is raised. The transmit interrupt says that some unmasked channel of its own is free again. Both interrupts come straight from registered state, so they follow a write in the cycle after the write edge.

Top module: `mbox_flag_ctrl`

## Requirements
- R1: After reset all flags read 0, both mask words read 32'hFFFF_FFFF, both control words read 0, and all four interrupts are low.
- R2: Word addresses 0-3 form processor 0's bank and 4-7 form processor 1's bank. In each bank, offset 0 is control, 1 is mask, 2 is flag set/clear (it reads 0), and 3 is flag status. Either port can read either bank. A write from a port reaches only that port's own bank.
- R3: In the control word, bit 0 enables the receive interrupt and bit 16 enables the transmit interrupt. All other control bits read 0.
- R4: When a port writes 1 to bit 16+n of its set/clear word, it raises its own flag n. Zero bits in the written word change nothing.
- R5: When a port writes 1 to bit n of its set/clear word, it lowers the partner's flag n and leaves its own flags alone. Zero bits in the written word change nothing.
- R6: If both ports write their set/clear words in the same cycle, every set and clear is applied. If the same flag is raised by its owner and lowered by the partner in that cycle, it ends up raised.
- R7: A receive interrupt is high when its receive enable is 1 and some channel n has partner flag n = 1 and mask bit n = 0.
- R8: A transmit interrupt is high when its transmit enable is 1 and some implemented channel n has own flag n = 0 and mask bit 16+n = 0.
- R9: Flags for channels at or above NCH read 0 in the status word, ignore set and clear, and never produce an interrupt.
- R10: Word 0x0FC (byte 0x3F0) reads NCH in bits 7:0. Word 0x0FD (byte 0x3F4) reads the major revision in bits 7:4 and the minor revision in bits 3:0. Writes to either word are ignored, and any other unmapped word reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| p0_we | input | 1 | Processor 0 write strobe |
| p0_addr | input | AW | Processor 0 word address |
| p0_wdata | input | 32 | Processor 0 write data |
| p0_rdata | output | 32 | Processor 0 read data for p0_addr, combinational |
| p1_we | input | 1 | Processor 1 write strobe |
| p1_addr | input | AW | Processor 1 word address |
| p1_wdata | input | 32 | Processor 1 write data |
| p1_rdata | output | 32 | Processor 1 read data for p1_addr, combinational |
| p0_rx_irq | output | 1 | Processor 0 receive interrupt |
| p0_tx_irq | output | 1 | Processor 0 transmit interrupt |
| p1_rx_irq | output | 1 | Processor 1 receive interrupt |
| p1_tx_irq | output | 1 | Processor 1 transmit interrupt |

## Verification
The assertions assume three things about the inputs. Reset is applied from time zero. The address and write-data inputs hold a known value on every clock edge after reset. Write strobes are single-cycle levels sampled at the rising edge, so every flag change can be traced to the set/clear write seen on the previous edge. The stimulus changes every input only on the falling edge and never leaves an input unknown. It keeps the strobes low until the internal reset release has passed. The random phase draws addresses mostly from the mapped words, so set, clear and same-cycle collisions occur often and still touch only defined inputs.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // Largest channel count the register layout can hold.
  localparam int CH_MAX = 16;

  // Word offsets inside a processor bank.
  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_MASK   = 2'd1,
    REG_SETCLR = 2'd2,
    REG_STAT   = 2'd3
  } bank_reg_e;

  // Global identification words (byte 0x3F0 and 0x3F4).
  localparam logic [9:0] WORD_CFG = 10'h0FC;
  localparam logic [9:0] WORD_VER = 10'h0FD;

  // Control word bit positions.
  localparam int CTRL_RX_BIT = 0;
  localparam int CTRL_TX_BIT = 16;

  typedef struct packed {
    logic ctrl_we;
    logic mask_we;
    logic scr_we;
  } bank_wr_t;

  function automatic logic [CH_MAX-1:0] chan_valid(input int nch);
    logic [CH_MAX-1:0] v;
    for (int i = 0; i < CH_MAX; i++) v[i] = (i < nch);
    return v;
  endfunction

endpackage

// File: rtl/mbox_port_dec.sv
module mbox_port_dec
  import mbox_pkg::*;
#(
  parameter int PORT = 0,
  parameter int AW   = 10
) (
  input  logic          we,
  input  logic [AW-1:0] addr,
  output bank_wr_t      wr
);

  logic own_bank;
  bank_reg_e sel;

  always_comb begin
    own_bank = (addr[AW-1:3] == '0) && (addr[2] == 1'(PORT));
    sel      = bank_reg_e'(addr[1:0]);
    wr.ctrl_we = we && own_bank && (sel == REG_CTRL);
    wr.mask_we = we && own_bank && (sel == REG_MASK);
    wr.scr_we  = we && own_bank && (sel == REG_SETCLR);
  end

endmodule

// File: rtl/mbox_flag_array.sv
module mbox_flag_array
  import mbox_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             scr_we,
  input  logic [1:0][31:0]       wdata,
  output logic [1:0][CH_MAX-1:0] flags
);

  localparam logic [CH_MAX-1:0] VALID = chan_valid(NCH);

  logic [1:0][CH_MAX-1:0] set_req;
  logic [1:0][CH_MAX-1:0] clr_req;
  logic [1:0][CH_MAX-1:0] flags_d;
  logic                   flags_ce;

  // Owner raises with the upper half, partner lowers with the lower half.
  for (genvar p = 0; p < 2; p++) begin : g_req
    always_comb begin
      set_req[p] = scr_we[p] ? (wdata[p][31:16] & VALID) : '0;
      clr_req[p] = scr_we[p] ? (wdata[p][15:0]  & VALID) : '0;
    end
  end

  // A raise beats a same-cycle lower of the same flag.
  for (genvar p = 0; p < 2; p++) begin : g_next
    always_comb begin
      flags_d[p] = ((flags[p] & ~clr_req[1-p]) | set_req[p]) & VALID;
    end
  end

  assign flags_ce = |scr_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else if (flags_ce) begin
      flags <= flags_d;
    end
  end

endmodule

// File: rtl/mbox_bank.sv
module mbox_bank
  import mbox_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic              mask_we,
  input  logic [31:0]       wdata,
  input  logic [CH_MAX-1:0] own_flags,
  input  logic [CH_MAX-1:0] partner_flags,
  output logic              rx_en,
  output logic              tx_en,
  output logic [31:0]       mask,
  output logic              rx_irq,
  output logic              tx_irq
);

  localparam logic [CH_MAX-1:0] VALID = chan_valid(NCH);

  logic              rx_en_d;
  logic              tx_en_d;
  logic [31:0]       mask_d;
  logic [CH_MAX-1:0] rx_pend;
  logic [CH_MAX-1:0] tx_pend;

  always_comb begin
    rx_en_d = ctrl_we ? wdata[CTRL_RX_BIT] : rx_en;
    tx_en_d = ctrl_we ? wdata[CTRL_TX_BIT] : tx_en;
    mask_d  = mask_we ? wdata : mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en <= 1'b0;
      tx_en <= 1'b0;
    end else if (ctrl_we) begin
      rx_en <= rx_en_d;
      tx_en <= tx_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '1;
    end else if (mask_we) begin
      mask <= mask_d;
    end
  end

  // Receive looks at raised partner flags, transmit at lowered own flags.
  always_comb begin
    rx_pend = partner_flags & ~mask[CH_MAX-1:0] & VALID;
    tx_pend = ~own_flags & ~mask[31:CH_MAX] & VALID;
    rx_irq  = rx_en & (|rx_pend);
    tx_irq  = tx_en & (|tx_pend);
  end

endmodule

// File: rtl/mbox_rdmux.sv
module mbox_rdmux
  import mbox_pkg::*;
#(
  parameter int NCH       = 16,
  parameter int AW        = 10,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic [AW-1:0]          addr,
  input  logic [1:0]             rx_en,
  input  logic [1:0]             tx_en,
  input  logic [1:0][31:0]       mask,
  input  logic [1:0][CH_MAX-1:0] flags,
  output logic [31:0]            rdata
);

  localparam logic [31:0] CFG_WORD = 32'(NCH) & 32'h0000_00FF;
  localparam logic [31:0] VER_WORD = {24'd0, 4'(VER_MAJOR), 4'(VER_MINOR)};

  logic      b;
  bank_reg_e sel;

  always_comb begin
    b     = addr[2];
    sel   = bank_reg_e'(addr[1:0]);
    rdata = '0;
    if (addr[AW-1:3] == '0) begin
      unique case (sel)
        REG_CTRL: begin
          rdata[CTRL_RX_BIT] = rx_en[b];
          rdata[CTRL_TX_BIT] = tx_en[b];
        end
        REG_MASK:   rdata = mask[b];
        REG_SETCLR: rdata = '0;
        REG_STAT:   rdata = {{(32-CH_MAX){1'b0}}, flags[b]};
        default:    rdata = '0;
      endcase
    end else if (addr == AW'(WORD_CFG)) begin
      rdata = CFG_WORD;
    end else if (addr == AW'(WORD_VER)) begin
      rdata = VER_WORD;
    end
  end

endmodule

// File: rtl/mbox_flag_ctrl.sv
module mbox_flag_ctrl
  import mbox_pkg::*;
#(
  parameter int NCH       = 16,
  parameter int AW        = 10,
  parameter int VER_MAJOR = 1,
  parameter int VER_MINOR = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          p0_we,
  input  logic [AW-1:0] p0_addr,
  input  logic [31:0]   p0_wdata,
  output logic [31:0]   p0_rdata,
  input  logic          p1_we,
  input  logic [AW-1:0] p1_addr,
  input  logic [31:0]   p1_wdata,
  output logic [31:0]   p1_rdata,
  output logic          p0_rx_irq,
  output logic          p0_tx_irq,
  output logic          p1_rx_irq,
  output logic          p1_tx_irq
);

  logic [1:0]             rst_sync;
  logic                   rst_int_n;
  logic [1:0]             we_v;
  logic [1:0][AW-1:0]     addr_v;
  logic [1:0][31:0]       wdata_v;
  logic [1:0][31:0]       rdata_v;
  bank_wr_t [1:0]         wr_v;
  logic [1:0]             scr_we_v;
  logic [1:0]             rx_en_v;
  logic [1:0]             tx_en_v;
  logic [1:0][31:0]       mask_v;
  logic [1:0]             rx_irq_v;
  logic [1:0]             tx_irq_v;
  logic [1:0][CH_MAX-1:0] flag_vec;

  // Reset: asserted at once, released two edges later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  assign we_v    = {p1_we, p0_we};
  assign addr_v  = {p1_addr, p0_addr};
  assign wdata_v = {p1_wdata, p0_wdata};

  for (genvar p = 0; p < 2; p++) begin : g_port
    mbox_port_dec #(.PORT(p), .AW(AW)) u_dec (
      .we   (we_v[p]),
      .addr (addr_v[p]),
      .wr   (wr_v[p])
    );

    assign scr_we_v[p] = wr_v[p].scr_we;

    mbox_bank #(.NCH(NCH)) u_bank (
      .clk           (clk),
      .rst_n         (rst_int_n),
      .ctrl_we       (wr_v[p].ctrl_we),
      .mask_we       (wr_v[p].mask_we),
      .wdata         (wdata_v[p]),
      .own_flags     (flag_vec[p]),
      .partner_flags (flag_vec[1-p]),
      .rx_en         (rx_en_v[p]),
      .tx_en         (tx_en_v[p]),
      .mask          (mask_v[p]),
      .rx_irq        (rx_irq_v[p]),
      .tx_irq        (tx_irq_v[p])
    );

    mbox_rdmux #(
      .NCH(NCH), .AW(AW), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
    ) u_rd (
      .addr  (addr_v[p]),
      .rx_en (rx_en_v),
      .tx_en (tx_en_v),
      .mask  (mask_v),
      .flags (flag_vec),
      .rdata (rdata_v[p])
    );
  end

  mbox_flag_array #(.NCH(NCH)) u_flags (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .scr_we (scr_we_v),
    .wdata  (wdata_v),
    .flags  (flag_vec)
  );

  assign p0_rdata  = rdata_v[0];
  assign p1_rdata  = rdata_v[1];
  assign p0_rx_irq = rx_irq_v[0];
  assign p0_tx_irq = tx_irq_v[0];
  assign p1_rx_irq = rx_irq_v[1];
  assign p1_tx_irq = tx_irq_v[1];

endmodule

// File: rtl/mbox_flag_ctrl_chk.sv
module mbox_flag_ctrl_chk #(
  parameter int NCH = 16,
  parameter int AW  = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          p0_we,
  input logic [AW-1:0] p0_addr,
  input logic [31:0]   p0_rdata,
  input logic          p1_we,
  input logic [AW-1:0] p1_addr,
  input logic [31:0]   p1_rdata,
  input logic          p0_rx_irq,
  input logic          p0_tx_irq,
  input logic          p1_rx_irq,
  input logic          p1_tx_irq,
  input logic [15:0]   flag0,
  input logic [15:0]   flag1
);

  localparam logic [15:0]   VALID = mbox_pkg::chan_valid(NCH);
  localparam logic [31:0]   HIGH  = ~{16'd0, VALID};
  localparam logic [AW-1:0] SCR0  = AW'(2);
  localparam logic [AW-1:0] STA0  = AW'(3);
  localparam logic [AW-1:0] SCR1  = AW'(6);
  localparam logic [AW-1:0] STA1  = AW'(7);
  localparam logic [AW-1:0] CFG   = AW'(10'h0FC);

  AST_OWNER_RAISES_FLAG0: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag0 & ~$past(flag0)) != 16'd0) |-> $past(p0_we && p0_addr == SCR0)); // R4
  AST_OWNER_RAISES_FLAG1: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag1 & ~$past(flag1)) != 16'd0) |-> $past(p1_we && p1_addr == SCR1)); // R4
  AST_PARTNER_LOWERS_FLAG0: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag0 & $past(flag0)) != 16'd0) |-> $past(p1_we && p1_addr == SCR1)); // R5
  AST_PARTNER_LOWERS_FLAG1: assert property (@(posedge clk) disable iff (!rst_n)
    ((~flag1 & $past(flag1)) != 16'd0) |-> $past(p0_we && p0_addr == SCR0)); // R5
  AST_RX0_NEEDS_PARTNER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    p0_rx_irq |-> (flag1 != 16'd0)); // R7
  AST_RX1_NEEDS_PARTNER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    p1_rx_irq |-> (flag0 != 16'd0)); // R7
  AST_TX0_NEEDS_FREE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    p0_tx_irq |-> ((flag0 & VALID) != VALID)); // R8
  AST_TX1_NEEDS_FREE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
    p1_tx_irq |-> ((flag1 & VALID) != VALID)); // R8
  AST_UNUSED_CHAN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((flag0 | flag1) & ~VALID) == 16'd0); // R9
  AST_STATUS0_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_addr == STA0 || p0_addr == STA1) |-> ((p0_rdata & HIGH) == 32'd0)); // R9
  AST_STATUS1_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_addr == STA0 || p1_addr == STA1) |-> ((p1_rdata & HIGH) == 32'd0)); // R9
  AST_CFG0_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (p0_addr == CFG) |-> (p0_rdata == 32'(NCH))); // R10
  AST_CFG1_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (p1_addr == CFG) |-> (p1_rdata == 32'(NCH))); // R10

endmodule

bind mbox_flag_ctrl mbox_flag_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .p0_we     (p0_we),
  .p0_addr   (p0_addr),
  .p0_rdata  (p0_rdata),
  .p1_we     (p1_we),
  .p1_addr   (p1_addr),
  .p1_rdata  (p1_rdata),
  .p0_rx_irq (p0_rx_irq),
  .p0_tx_irq (p0_tx_irq),
  .p1_rx_irq (p1_rx_irq),
  .p1_tx_irq (p1_tx_irq),
  .flag0     (flag_vec[0]),
  .flag1     (flag_vec[1])
);

// File: tb/mbox_flag_ctrl_test.sv
module mbox_flag_ctrl_test;

  localparam int NCH  = 12;
  localparam int AW   = 10;
  localparam int VMAJ = 2;
  localparam int VMIN = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          p0_we = 1'b0;
  logic [AW-1:0] p0_addr = '0;
  logic [31:0]   p0_wdata = '0;
  logic          p1_we = 1'b0;
  logic [AW-1:0] p1_addr = '0;
  logic [31:0]   p1_wdata = '0;
  logic [31:0]   p0_rdata, p1_rdata;
  logic          p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq;

  always #4 clk = ~clk;

  mbox_flag_ctrl #(.NCH(NCH), .AW(AW), .VER_MAJOR(VMAJ), .VER_MINOR(VMIN)) uut (
    .clk(clk), .rst_n(rst_n),
    .p0_we(p0_we), .p0_addr(p0_addr), .p0_wdata(p0_wdata), .p0_rdata(p0_rdata),
    .p1_we(p1_we), .p1_addr(p1_addr), .p1_wdata(p1_wdata), .p1_rdata(p1_rdata),
    .p0_rx_irq(p0_rx_irq), .p0_tx_irq(p0_tx_irq),
    .p1_rx_irq(p1_rx_irq), .p1_tx_irq(p1_tx_irq)
  );

  // Behavioural reference state.
  logic        m_rx [2];
  logic        m_tx [2];
  logic [31:0] m_mask [2];
  logic [15:0] m_flag [2];
  logic [15:0] valid;

  int    n_chk  = 0;
  int    n_fail = 0;
  bit    run    = 0;
  bit    done   = 0;
  string tag    = "R1";

  initial begin
    valid = '0;
    for (int i = 0; i < NCH; i++) valid[i] = 1'b1;
  end

  function automatic logic [31:0] exp_rd(input logic [AW-1:0] a);
    int w;
    int b;
    w = int'(a);
    if (w < 8) begin
      b = (w >> 2) & 1;
      case (w & 3)
        0:       return {15'd0, m_tx[b], 15'd0, m_rx[b]};
        1:       return m_mask[b];
        2:       return 32'd0;
        default: return {16'd0, m_flag[b]};
      endcase
    end
    if (w == 252) return 32'(NCH);
    if (w == 253) return {24'd0, 4'(VMAJ), 4'(VMIN)};
    return 32'd0;
  endfunction

  function automatic logic exp_rx(input int p);
    return m_rx[p] && ((m_flag[1-p] & ~m_mask[p][15:0]) != 16'd0);
  endfunction

  function automatic logic exp_tx(input int p);
    return m_tx[p] && ((~m_flag[p] & valid & ~m_mask[p][31:16]) != 16'd0);
  endfunction

  // Reference update on every rising edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        m_rx[p] = 1'b0; m_tx[p] = 1'b0; m_mask[p] = 32'hFFFF_FFFF; m_flag[p] = 16'd0;
      end
    end else if (run) begin
      logic [15:0] setv [2];
      logic [15:0] clrv [2];
      logic          we   [2];
      logic [AW-1:0] ad   [2];
      logic [31:0]   wd   [2];
      we[0] = p0_we; ad[0] = p0_addr; wd[0] = p0_wdata;
      we[1] = p1_we; ad[1] = p1_addr; wd[1] = p1_wdata;
      for (int p = 0; p < 2; p++) begin
        setv[p] = 16'd0; clrv[p] = 16'd0;
        if (we[p] && int'(ad[p]) == 4*p)     begin m_rx[p] = wd[p][0]; m_tx[p] = wd[p][16]; end
        if (we[p] && int'(ad[p]) == 4*p + 1) m_mask[p] = wd[p];
        if (we[p] && int'(ad[p]) == 4*p + 2) begin
          setv[p] = wd[p][31:16] & valid;
          clrv[p] = wd[p][15:0] & valid;
        end
      end
      for (int p = 0; p < 2; p++) m_flag[p] = (m_flag[p] & ~clrv[1-p]) | setv[p];
    end
  end

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp,
                       input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference.
  always @(negedge clk) begin
    if (run) begin
      #1;
      check(tag, 32'(p0_rx_irq), 32'(exp_rx(0)), "p0_rx_irq");
      check(tag, 32'(p0_tx_irq), 32'(exp_tx(0)), "p0_tx_irq");
      check(tag, 32'(p1_rx_irq), 32'(exp_rx(1)), "p1_rx_irq");
      check(tag, 32'(p1_tx_irq), 32'(exp_tx(1)), "p1_tx_irq");
      check(tag, p0_rdata, exp_rd(p0_addr), "p0_rdata");
      check(tag, p1_rdata, exp_rd(p1_addr), "p1_rdata");
    end
  end

  task automatic wr0(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); p0_we = 1'b1; p0_addr = a; p0_wdata = d;
    @(negedge clk); p0_we = 1'b0;
  endtask

  task automatic wr1(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); p1_we = 1'b1; p1_addr = a; p1_wdata = d;
    @(negedge clk); p1_we = 1'b0;
  endtask

  task automatic wr_both(input logic [31:0] d0, input logic [31:0] d1);
    @(negedge clk);
    p0_we = 1'b1; p0_addr = AW'(2); p0_wdata = d0;
    p1_we = 1'b1; p1_addr = AW'(6); p1_wdata = d1;
    @(negedge clk); p0_we = 1'b0; p1_we = 1'b0;
  endtask

  task automatic rd0(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); p0_we = 1'b0; p0_addr = a;
    #2; check(req, p0_rdata, exp, "p0 read");
  endtask

  task automatic rd1(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); p1_we = 1'b0; p1_addr = a;
    #2; check(req, p1_rdata, exp, "p1 read");
  endtask

  // Order: p0_rx, p0_tx, p1_rx, p1_tx.
  task automatic irq_chk(input logic [3:0] exp, input string req);
    #2; check(req, {28'd0, p0_rx_irq, p0_tx_irq, p1_rx_irq, p1_tx_irq}, {28'd0, exp}, "irqs");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: state held in reset.
    repeat (3) @(posedge clk);
    #2;
    p0_addr = AW'(1); p1_addr = AW'(5); #1;
    check("R1", p0_rdata, 32'hFFFF_FFFF, "bank0 mask in reset");
    check("R1", p1_rdata, 32'hFFFF_FFFF, "bank1 mask in reset");
    p0_addr = AW'(0); p1_addr = AW'(7); #1;
    check("R1", p0_rdata, 32'd0, "bank0 control in reset");
    check("R1", p1_rdata, 32'd0, "bank1 status in reset");
    irq_chk(4'b0000, "R1");
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1;
    rd0(AW'(3), 32'd0, "R1");
    irq_chk(4'b0000, "R1");

    tag = "R10";
    rd0(AW'(10'h0FC), 32'd12, "R10");
    rd1(AW'(10'h0FD), 32'h25, "R10");
    wr0(AW'(10'h0FC), 32'hFFFF_FFFF);
    rd0(AW'(10'h0FC), 32'd12, "R10");
    rd1(AW'(10'h1A0), 32'd0, "R10");

    tag = "R3";
    wr0(AW'(0), 32'hFFFF_FFFF);
    rd0(AW'(0), 32'h0001_0001, "R3");
    irq_chk(4'b0000, "R3");

    tag = "R2";
    wr1(AW'(1), 32'd0);
    rd0(AW'(1), 32'hFFFF_FFFF, "R2");
    wr0(AW'(4), 32'hFFFF_FFFF);
    rd1(AW'(4), 32'd0, "R2");
    rd1(AW'(0), 32'h0001_0001, "R2");
    rd0(AW'(2), 32'd0, "R2");

    tag = "R8";
    wr0(AW'(1), 32'hFFF7_FFFF);
    irq_chk(4'b0100, "R8");
    wr0(AW'(2), 32'h0008_0000);
    irq_chk(4'b0000, "R8");
    rd0(AW'(3), 32'h8, "R4");

    tag = "R7";
    wr1(AW'(4), 32'h1);
    wr1(AW'(5), 32'hFFFF_FFF7);
    irq_chk(4'b0010, "R7");
    wr1(AW'(6), 32'h8);
    irq_chk(4'b0100, "R7");
    rd0(AW'(3), 32'd0, "R5");

    tag = "R4";
    wr0(AW'(2), 32'h0020_0000);
    rd0(AW'(3), 32'h20, "R4");
    wr0(AW'(2), 32'd0);
    rd0(AW'(3), 32'h20, "R4");
    tag = "R5";
    wr1(AW'(6), 32'd0);
    rd0(AW'(3), 32'h20, "R5");
    wr0(AW'(2), 32'h20);
    rd0(AW'(3), 32'h20, "R5");

    tag = "R6";
    wr_both(32'h0060_0000, 32'h20);
    rd0(AW'(3), 32'h60, "R6");
    wr_both(32'h0002_0000, 32'h40);
    rd0(AW'(3), 32'h22, "R6");
    wr1(AW'(6), 32'h0004_0000);
    wr_both(32'h4, 32'h0200_0000);
    rd1(AW'(7), 32'h200, "R6");
    rd0(AW'(3), 32'h22, "R6");

    tag = "R9";
    wr0(AW'(2), 32'hF000_0000);
    rd0(AW'(3), 32'h22, "R9");
    wr0(AW'(2), 32'h0FFF_0000);
    rd0(AW'(3), 32'hFFF, "R9");
    wr0(AW'(1), 32'd0);
    irq_chk(4'b1010, "R9");
    wr1(AW'(6), 32'h0000_F000);
    rd1(AW'(3), 32'hFFF, "R9");

    tag = "R2/R3/R4/R5/R6/R7/R8/R10";
    for (int i = 0; i < 3000; i++) begin
      int sel0, sel1;
      @(negedge clk);
      sel0 = int'($urandom_range(0, 11));
      sel1 = int'($urandom_range(0, 11));
      p0_we = 1'($urandom_range(0, 1));
      p1_we = 1'($urandom_range(0, 1));
      p0_addr = (sel0 < 8) ? AW'(sel0) : (sel0 == 8) ? AW'(10'h0FC) :
                (sel0 == 9) ? AW'(10'h0FD) : AW'($urandom);
      p1_addr = (sel1 < 8) ? AW'(sel1) : (sel1 == 8) ? AW'(10'h0FC) :
                (sel1 == 9) ? AW'(10'h0FD) : AW'($urandom);
      p0_wdata = $urandom & $urandom;
      p1_wdata = $urandom & $urandom;
    end
    @(negedge clk); p0_we = 1'b0; p1_we = 1'b0;
    repeat (2) @(negedge clk);
    run = 0;
    finish_run();
  end

endmodule